// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block collects the events of two timer/counters and turns them into interrupt requests. Timer 1 has two compare-match events, A and B, and an overflow event. Timer 0 has only an overflow event. Each event pulse sets a sticky flag. The flags and their enables sit in two 8-bit registers behind a simple register bus.

The block combines each flag with its enable and with a global interrupt-enable input. When more than one combination is active, it picks one, and it presents a single request with a fixed vector number. The processor acknowledges by returning that vector number, and the acknowledge clears the serviced flag. Software can also clear a flag by writing a one to its bit. That clear passes through one synchronisation register before it takes effect.

The event source order on `evt_pulse` is fixed:

| Index | Event |
|-------|-------|
| 0 | Compare match A, timer 1 |
| 1 | Compare match B, timer 1 |
| 2 | Timer 1 overflow |
| 3 | Timer 0 overflow |

Top module: `tmr_irq_ctrl`

## Requirements
- R1: The flag register sits at address `FLAG_ADDR` (default 0x38). Its bit positions are 6 for compare A, 5 for compare B, 2 for timer 1 overflow and 1 for timer 0 overflow. Bits 7, 4, 3 and 0 always read zero, and writes to them have no effect.
- R2: The enable register sits at address `MASK_ADDR` (default 0x39) and uses the same bit positions for the matching enables. A write stores only bits 6, 5, 2 and 1, and its other bits always read zero.
- R3: `bus_rdata` is registered. It shows the register addressed in the cycle before, and it reads zero for any other address. A read never changes any state.
- R4: `irq_req` is registered. It is one in the cycle after the global enable, a matching enable bit and its flag were all one together, and it is zero otherwise.
- R5: The vector numbers are 3 for compare A, 4 for compare B, 5 for timer 1 overflow and 6 for timer 0 overflow. When several requests are active, the lowest vector number wins.
- R6: An acknowledge (`ack_valid` high) whose `ack_vec` matches a source's vector clears that flag at the same clock edge. An acknowledge with any other number has no effect.
- R7: Writing a one to a flag bit clears that flag one clock edge after the write edge. Writing a zero leaves the flag unchanged.
- R8: An event pulse sets its flag at the next edge. If an event meets a clear of the same flag at the same edge, the flag stays set.
- R9: Reset is synchronous and active high. It clears both registers, `irq_req` and `irq_vec`.
- R10: `irq_vec` is zero whenever `irq_req` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 4 | Event pulses, in the index order listed above |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| gie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Pending interrupt request |
| irq_vec | output | VEC_W | Vector number of the request |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vec | input | VEC_W | Vector number being acknowledged |

## Verification
The bench builds the block with its default parameters: a 6-bit address, the flag register at 0x38 and the enable register at 0x39. With four sources, all 16 flag patterns can be crossed with all 16 enable patterns, under both values of the global enable. This checks every priority decision and every gating case, with the expected vector computed as three plus the lowest active index. Directed sequences then count edges to check:
- the delayed write-one clear against the same-edge acknowledge clear;
- an event that wins over a clear at the same edge;
- that writes to the reserved bits of both registers have no effect.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int NSRC     = 4;
  localparam int REG_W    = 8;
  localparam int VEC_BASE = 3;
  localparam int SRC_BIT [NSRC] = '{6, 5, 2, 1};

  function automatic logic [REG_W-1:0] impl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[SRC_BIT[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] pack_bits(input logic [NSRC-1:0] v);
    logic [REG_W-1:0] b;
    b = '0;
    for (int i = 0; i < NSRC; i++) b[SRC_BIT[i]] = v[i];
    return b;
  endfunction

  function automatic logic [NSRC-1:0] unpack_bits(input logic [REG_W-1:0] b);
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i++) v[i] = b[SRC_BIT[i]];
    return v;
  endfunction
endpackage

// File: rtl/tic_flag_bank.sv
module tic_flag_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr_wr,
  input  logic [NSRC-1:0] ack_hit,
  output logic [NSRC-1:0] flag
);
  logic [NSRC-1:0] clr_sync;

  always_ff @(posedge clk) begin
    if (rst) clr_sync <= '0;
    else     clr_sync <= clr_wr;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag[i] <= 1'b0;
      else if (evt[i]) flag[i] <= 1'b1;
      else if (clr_sync[i] || ack_hit[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tic_regif.sv
module tic_regif
  import tic_pkg::*;
#(
  parameter int              ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h38,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h39
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NSRC-1:0]   flag,
  output logic [NSRC-1:0]   en,
  output logic [NSRC-1:0]   clr_wr,
  output logic [REG_W-1:0]  rdata
);
  logic hit_flag, hit_mask;
  assign hit_flag = (addr == FLAG_ADDR);
  assign hit_mask = (addr == MASK_ADDR);

  assign clr_wr = (wr && hit_flag) ? unpack_bits(wdata) : '0;

  always_ff @(posedge clk) begin
    if (rst)                  en <= '0;
    else if (wr && hit_mask)  en <= unpack_bits(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata <= '0;
    else if (hit_flag) rdata <= pack_bits(flag);
    else if (hit_mask) rdata <= pack_bits(en);
    else               rdata <= '0;
  end
endmodule

// File: rtl/tic_prio_enc.sv
module tic_prio_enc #(
  parameter int NSRC     = 4,
  parameter int VEC_W    = 4,
  parameter int VEC_BASE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  pend,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  logic [VEC_W-1:0] sel_vec;

  always_comb begin
    sel_vec = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (pend[i]) sel_vec = VEC_W'(VEC_BASE + i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      vec <= '0;
    end else begin
      req <= |pend;
      vec <= sel_vec;
    end
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tic_pkg::*;
#(
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h38,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h39,
  parameter int                VEC_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   evt_pulse,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              gie,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              ack_valid,
  input  logic [VEC_W-1:0]  ack_vec
);
  logic [NSRC-1:0] flag_vec, en_vec, clr_wr, ack_hit, pend;

  for (genvar i = 0; i < NSRC; i++) begin : g_ack
    assign ack_hit[i] = ack_valid && (ack_vec == VEC_W'(VEC_BASE + i));
  end

  assign pend = flag_vec & en_vec & {NSRC{gie}};

  tic_regif #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .MASK_ADDR(MASK_ADDR)) u_regif (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .flag(flag_vec), .en(en_vec), .clr_wr(clr_wr), .rdata(bus_rdata)
  );

  tic_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_pulse), .clr_wr(clr_wr),
    .ack_hit(ack_hit), .flag(flag_vec)
  );

  tic_prio_enc #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_prio (
    .clk(clk), .rst(rst), .pend(pend), .req(irq_req), .vec(irq_vec)
  );
endmodule

// File: rtl/tic_checker.sv
module tic_checker
  import tic_pkg::*;
#(
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NSRC-1:0]  evt_pulse,
  input logic [REG_W-1:0] bus_rdata,
  input logic             gie,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             ack_valid,
  input logic [VEC_W-1:0] ack_vec,
  input logic [NSRC-1:0]  flag_vec,
  input logic [NSRC-1:0]  en_vec
);
  a_r1_reserved_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~impl_mask()) == '0);

  a_r4_req_needs_gie: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gie));

  a_r5_vec_range: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec < VEC_W'(VEC_BASE + NSRC)));

  a_r10_idle_vec_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> irq_vec == '0);

  a_r8_event_sets: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse != '0) |=> ((flag_vec & $past(evt_pulse)) == $past(evt_pulse)));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_vec == VEC_W'(VEC_BASE) && !evt_pulse[0]) |=> !flag_vec[0]);

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (flag_vec == '0 && en_vec == '0 && !irq_req));
endmodule

bind tmr_irq_ctrl tic_checker #(.VEC_W(VEC_W)) u_tic_checker (
  .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .bus_rdata(bus_rdata),
  .gie(gie), .irq_req(irq_req), .irq_vec(irq_vec), .ack_valid(ack_valid),
  .ack_vec(ack_vec), .flag_vec(flag_vec), .en_vec(en_vec)
);

// File: tb/test_tmr_irq_ctrl.sv
module test_tmr_irq_ctrl;
  localparam logic [5:0] FADDR = 6'h38;
  localparam logic [5:0] MADDR = 6'h39;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] evt_pulse = '0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       gie = 1'b0;
  logic       irq_req;
  logic [3:0] irq_vec;
  logic       ack_valid = 1'b0;
  logic [3:0] ack_vec = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_irq_ctrl i_tmr_irq_ctrl (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
    .irq_req(irq_req), .irq_vec(irq_vec), .ack_valid(ack_valid), .ack_vec(ack_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bit positions 6,5,2,1 for sources 0..3
  function automatic logic [7:0] to_byte(input logic [3:0] v);
    return {1'b0, v[0], v[1], 2'b00, v[2], v[3], 1'b0};
  endfunction

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic fire(input logic [3:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic ack(input logic [3:0] v);
    @(negedge clk); ack_valid = 1'b1; ack_vec = v;
    @(negedge clk); ack_valid = 1'b0; ack_vec = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq_req", irq_req, 0);
    chk("R9 irq_vec", irq_vec, 0);
    rd_reg(FADDR, rd); chk("R9 flags", rd, 0);
    rd_reg(MADDR, rd); chk("R9 mask", rd, 0);

    // R2 reserved enable bits
    wr_reg(MADDR, 8'hFF);
    rd_reg(MADDR, rd); chk("R2 mask reserved", rd, 8'h66);
    wr_reg(MADDR, 8'h00);
    // R1 reserved flag bits: writing to them does nothing, still zero
    fire(4'hF);
    wr_reg(FADDR, 8'h99);
    @(negedge clk);
    rd_reg(FADDR, rd); chk("R1 flag layout/reserved", rd, 8'h66);
    // R3 other address and no read side effect
    rd_reg(6'h10, rd); chk("R3 other addr", rd, 0);
    rd_reg(FADDR, rd); chk("R3 reread", rd, 8'h66);
    wr_reg(FADDR, 8'hFF); @(negedge clk);
    rd_reg(FADDR, rd); chk("R7 clear all", rd, 0);

    // Exhaustive sweep R4 R5 R10
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 16; e++) begin
        for (int f = 0; f < 16; f++) begin
          logic [3:0] p;
          int lo;
          gie = g[0];
          wr_reg(MADDR, to_byte(e[3:0]));
          fire(f[3:0]);
          @(negedge clk);
          p = f[3:0] & e[3:0] & {4{g[0]}};
          lo = 0;
          for (int k = 3; k >= 0; k--) if (p[k]) lo = 3 + k;
          chk("R4 req", irq_req, (p != 0));
          chk("R5 R10 vec", irq_vec, lo);
          if (e == 0) begin
            rd_reg(FADDR, rd); chk("R8 flags set", rd, to_byte(f[3:0]));
          end
          wr_reg(FADDR, 8'hFF);
          @(negedge clk);
        end
      end
    end

    // R6 ack clears same edge, priority falls to next
    gie = 1'b1;
    wr_reg(MADDR, 8'h66);
    fire(4'b0011);
    @(negedge clk);
    chk("R5 prio A", irq_vec, 3);
    ack(4'd3);        // flag A cleared at this edge; req stale for one cycle
    @(negedge clk);
    chk("R6 ack next vec", irq_vec, 4);
    ack(4'd9);        // unrelated number
    @(negedge clk);
    chk("R6 foreign ack ignored", irq_vec, 4);
    ack(4'd4);
    @(negedge clk);
    chk("R6 ack last", irq_req, 0);

    // R7 write-one clear takes one extra edge; write-zero no effect
    fire(4'b1000);
    @(negedge clk);
    chk("R7 pre", irq_vec, 6);
    wr_reg(FADDR, 8'h00);
    @(negedge clk); @(negedge clk);
    chk("R7 zero write keeps", irq_req, 1);
    wr_reg(FADDR, 8'h02);
    @(negedge clk);
    chk("R7 sync delay", irq_req, 1);
    @(negedge clk);
    chk("R7 cleared", irq_req, 0);

    // R8 event wins over ack
    fire(4'b0100);
    @(negedge clk); ack_valid = 1'b1; ack_vec = 4'd5; evt_pulse = 4'b0100;
    @(negedge clk); ack_valid = 1'b0; evt_pulse = '0;
    rd_reg(FADDR, rd); chk("R8 set beats ack", rd, 8'h04);
    // R8 event wins over synced write clear
    @(negedge clk); bus_addr = FADDR; bus_wr = 1'b1; bus_wdata = 8'h04;
    @(negedge clk); bus_wr = 1'b0; evt_pulse = 4'b0100;
    @(negedge clk); evt_pulse = '0;
    @(negedge clk);
    rd_reg(FADDR, rd); chk("R8 set beats write clear", rd, 8'h04);

    // R9 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 req after reset", irq_req, 0);
    rd_reg(FADDR, rd); chk("R9 flags after reset", rd, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule